// File: doc/BRIEF.md
# Parallel I/O Controller with Two-Way Peripheral Multiplexing

This block manages 32 general-purpose pins from a small register bus. Each pin is owned either by the controller, which then drives it from an output-data register or samples it as an input, or by one of two on-chip peripherals, A or B. For a peripheral-owned pin the pad level is passed to the selected peripheral and that peripheral's output level drives the pad. The output of the other peripheral is ignored.

Every control bit lives in a status register. That register is changed only through a write-1-to-set register and a write-1-to-clear register. Controller-owned input pins pass through a two-flop synchronizer. A change in the latched level records a per-pin change flag. One level interrupt is raised for every flagged pin whose mask bit is set, and reading the flag register clears it.

An undriven pad reads back as its pull-up enable bit, which emulates a weak pull-up. The input-filter and multi-driver bits are stored and read back only.

Top module: `pio_mux_ctrl`

## Requirements
- R1: After reset, ownership status (0x08) reads 0xFFFFFFFF. Output-enable status (0x18), output data (0x38), pin data (0x3C), mask status (0x48) and change flags (0x4C) all read 0, and `irq` is 0.
- R2: For the pairs with set/clear/status at 0x00/0x04/0x08 (ownership), 0x10/0x14/0x18 (output enable), 0x20/0x24/0x28 (filter), 0x40/0x44/0x48 (interrupt mask), 0x50/0x54/0x58 (multi-driver) and 0xA0/0xA4/0xA8 (output-write enable), a write changes only the bits written as 1. The pull-up pair is reversed: 0x64 sets, 0x60 clears, and 0x68 reads the status.
- R3: Writing 1s to 0x70 clears select bits, which routes those pins to A. Writing 1s to 0x74 sets them, which routes to B. The select status reads at 0x78.
- R4: A write to 0x30 sets output-data bits and a write to 0x34 clears them. A write to 0x38 replaces only the bits whose output-write-enable bit is 1. Output data reads at 0x38.
- R5: On a controller-owned pin, `pad_oe` equals its output-enable bit and `pad_out` equals output data AND output enable.
- R6: A pad is latched only while the pin is controller-owned and its output enable is 0. The latched level goes through two synchronizer flops, and the level is 0 when `pad_drv` is 0. Offset 0x3C returns the latched level where the pad was driven and the pull-up bit where it was undriven.
- R7: A change of a latched level sets that pin's bit in 0x4C on the same edge. `irq` is 1 exactly when some flag bit and its mask bit are both 1.
- R8: A read strobe at 0x4C returns the flags and clears them on that edge, and `irq` falls after that edge. A change arriving on the same edge is kept.
- R9: On a pin not owned by the controller, `pad_oe` is 1. `pad_out` follows the selected peripheral's input. `pad_in` is forwarded only to the selected peripheral's output, and the other peripheral sees 0.
- R10: Only the low 9 address bits are decoded. Reads of write-only or unmapped offsets, for example 0x30 and 0x1FC, return 0. Writes to read-only or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Byte address; low 9 bits decoded |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe (needed for clear-on-read) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Pad input levels |
| pad_drv | input | 32 | 1 where something drives the pad |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| per_a_in | input | 32 | Peripheral A output levels |
| per_a_out | output | 32 | Pad levels forwarded to peripheral A |
| per_b_in | input | 32 | Peripheral B output levels |
| per_b_out | output | 32 | Pad levels forwarded to peripheral B |
| irq | output | 1 | Level interrupt |

## Verification
Register writes show up in read data and on `pad_out`/`pad_oe` one edge after the write strobe. Routing and forwarding are combinational and are checked in the same half cycle. A pad input change that is applied at a falling edge reaches the 0x3C value, the flag register and `irq` on the third rising edge, so the bench waits exactly three rising edges and samples at the next falling edge. The same-edge conflict between a change and a flag read is set up so that the read strobe lands on that third edge.

// File: rtl/pio_mux_ctrl.sv
module pio_mux_ctrl #(
  parameter int N  = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  reg_rdata,
  input  logic [N-1:0]  pad_in,
  input  logic [N-1:0]  pad_drv,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_oe,
  input  logic [N-1:0]  per_a_in,
  output logic [N-1:0]  per_a_out,
  input  logic [N-1:0]  per_b_in,
  output logic [N-1:0]  per_b_out,
  output logic          irq
);
  localparam int WIN = 9;

  logic [WIN-1:0] a;
  logic [N-1:0] own, oen, filt, imsk, mdrv, pull, sel, owen, odata;
  logic [N-1:0] s1_in, s2_in, s1_drv, s2_drv, latch, undrv, flags;
  logic [N-1:0] samp, nval, chg;
  logic         flag_rd;

  assign a       = reg_addr[WIN-1:0];
  assign samp    = own & ~oen;
  assign nval    = s2_in & s2_drv;
  assign chg     = samp & (nval ^ latch);
  assign flag_rd = reg_re && a == 9'h04C;
  assign irq     = |(flags & imsk);

  assign pad_oe    = own & oen | ~own;
  assign pad_out   = own & odata & oen | ~own & (sel & per_b_in | ~sel & per_a_in);
  assign per_a_out = ~own & ~sel & pad_in;
  assign per_b_out = ~own &  sel & pad_in;

  function automatic logic [N-1:0] upd(input logic [N-1:0] cur,
                                       input logic set, input logic clr,
                                       input logic [N-1:0] d);
    return set ? (cur | d) : clr ? (cur & ~d) : cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own <= '1; oen <= '0; filt <= '0; imsk <= '0; mdrv <= '0;
      pull <= '0; sel <= '0; owen <= '0; odata <= '0;
    end else if (reg_we) begin
      own  <= upd(own,  a == 9'h000, a == 9'h004, reg_wdata);
      oen  <= upd(oen,  a == 9'h010, a == 9'h014, reg_wdata);
      filt <= upd(filt, a == 9'h020, a == 9'h024, reg_wdata);
      imsk <= upd(imsk, a == 9'h040, a == 9'h044, reg_wdata);
      mdrv <= upd(mdrv, a == 9'h050, a == 9'h054, reg_wdata);
      pull <= upd(pull, a == 9'h064, a == 9'h060, reg_wdata);
      sel  <= upd(sel,  a == 9'h074, a == 9'h070, reg_wdata);
      owen <= upd(owen, a == 9'h0A0, a == 9'h0A4, reg_wdata);
      if (a == 9'h038) odata <= (odata & ~owen) | (reg_wdata & owen);
      else             odata <= upd(odata, a == 9'h030, a == 9'h034, reg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_in <= '0; s2_in <= '0; s1_drv <= '0; s2_drv <= '0;
      latch <= '0; undrv <= '1; flags <= '0;
    end else begin
      s1_in  <= pad_in;  s2_in  <= s1_in;
      s1_drv <= pad_drv; s2_drv <= s1_drv;
      latch  <= (latch & ~samp) | (nval & samp);
      undrv  <= (undrv & ~samp) | (~s2_drv & samp);
      flags  <= (flag_rd ? '0 : flags) | chg;
    end
  end

  always_comb begin
    case (a)
      9'h008:  reg_rdata = own;
      9'h018:  reg_rdata = oen;
      9'h028:  reg_rdata = filt;
      9'h038:  reg_rdata = odata;
      9'h03C:  reg_rdata = (latch & ~undrv) | (pull & undrv);
      9'h048:  reg_rdata = imsk;
      9'h04C:  reg_rdata = flags;
      9'h058:  reg_rdata = mdrv;
      9'h068:  reg_rdata = pull;
      9'h078:  reg_rdata = sel;
      9'h0A8:  reg_rdata = owen;
      default: reg_rdata = '0;
    endcase
  end

  p_set_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && a == 9'h010) |=> ((oen & $past(reg_wdata)) == $past(reg_wdata)) &&
                                (((oen ^ $past(oen)) & ~$past(reg_wdata)) == '0));

  p_odsr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && a == 9'h038) |=> ((odata ^ $past(odata)) & ~$past(owen)) == '0);

  p_flag_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags)) & ~$past(samp)) == '0);

  p_clr_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && chg == '0) |=> !irq);

  p_one_periph_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (per_a_out & per_b_out) == '0);
endmodule

// File: tb/pio_mux_ctrl_tb.sv
module pio_mux_ctrl_tb;
  logic        clk = 0, rst_n = 0, reg_we = 0, reg_re = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [31:0] pad_in = '0, pad_drv = '0, pad_out, pad_oe;
  logic [31:0] per_a_in = '0, per_b_in = '0, per_a_out, per_b_out;
  logic        irq;
  int checks = 0, errors = 0;
  logic [31:0] m [8];
  logic [31:0] r;

  always #10 clk = ~clk;

  pio_mux_ctrl u_dut (.*);

  function automatic logic [8:0] off_set(int k);
    case (k) 0: return 9'h000; 1: return 9'h010; 2: return 9'h020; 3: return 9'h040;
      4: return 9'h050; 5: return 9'h064; 6: return 9'h074; default: return 9'h0A0; endcase
  endfunction
  function automatic logic [8:0] off_clr(int k);
    case (k) 5: return 9'h060; 6: return 9'h070; default: return off_set(k) + 9'h4; endcase
  endfunction
  function automatic logic [8:0] off_st(int k);
    case (k) 5: return 9'h068; 6: return 9'h078; default: return off_set(k) + 9'h8; endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] ad, input logic [31:0] d);
    reg_we = 1; reg_addr = ad; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] ad, output logic [31:0] d);
    reg_re = 1; reg_addr = ad;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_re = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    m[0] = '1;
    for (int i = 1; i < 8; i++) m[i] = '0;
    idle(2); rst_n = 1; idle(1);

    rd(12'h008, r); chk("R1 own", r, 32'hFFFF_FFFF);
    rd(12'h018, r); chk("R1 oen", r, 0);
    rd(12'h03C, r); chk("R1 pin", r, 0);
    rd(12'h04C, r); chk("R1 flags", r, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    for (int i = 0; i < 60; i++) begin
      int k;
      logic [31:0] d;
      logic s;
      k = $urandom_range(0, 7);
      d = $urandom;
      s = $urandom_range(0, 1);
      wr({3'b0, s ? off_set(k) : off_clr(k)}, d);
      m[k] = s ? (m[k] | d) : (m[k] & ~d);
      rd({3'b0, off_st(k)}, r);
      chk(k == 6 ? "R3 select random" : "R2 triplet random", r, m[k]);
    end
    wr(12'h004, 32'h0000_0001); m[0] &= ~32'h1;
    rd(12'h008, r); chk("R2 ownership clear bit0", r, m[0]);
    wr(12'h208, 32'h0);
    rd(12'h208, r); chk("R10 status write ignored / alias", r, m[0]);
    wr(12'h404, 32'h0000_0002); m[0] &= ~32'h2;
    rd(12'h008, r); chk("R10 alias write", r, m[0]);

    wr(12'h000, '1); wr(12'h014, '1); wr(12'h0A4, '1); wr(12'h044, '1);
    wr(12'h060, '1); wr(12'h070, '1);
    rd(12'h068, r); chk("R2 pull cleared", r, 0);
    rd(12'h078, r); chk("R3 all to A", r, 0);

    wr(12'h030, 32'h0F); wr(12'h034, 32'h03);
    rd(12'h038, r); chk("R4 set/clear", r, 32'h0C);
    wr(12'h0A0, 32'hFF00);
    wr(12'h038, 32'hAAAA_AAAA);
    rd(12'h038, r); chk("R4 masked write", r, 32'hAA0C);
    wr(12'h010, 32'hFF0F);
    chk("R5 pad_oe", pad_oe, 32'hFF0F);
    chk("R5 pad_out", pad_out, 32'hAA0C);
    rd(12'h030, r); chk("R10 write-only reads 0", r, 0);
    rd(12'h1FC, r); chk("R10 unmapped reads 0", r, 0);

    wr(12'h040, 32'h0010_0000);
    pad_drv = 32'h00B0_0000; idle(3);
    rd(12'h04C, r); chk("R7 no change no flag", r, 0);
    pad_in[20] = 1; idle(3);
    chk("R7 irq on change", {31'b0, irq}, 1);
    rd(12'h03C, r); chk("R6 pin data", r, 32'h0010_0000);
    rd(12'h04C, r); chk("R8 flag read", r, 32'h0010_0000);
    chk("R8 irq cleared", {31'b0, irq}, 0);
    rd(12'h04C, r); chk("R8 flags zero", r, 0);
    pad_in[21] = 1; idle(3);
    chk("R7 masked no irq", {31'b0, irq}, 0);
    rd(12'h04C, r); chk("R7 masked flag", r, 32'h0020_0000);
    wr(12'h010, 32'h0080_0000);
    pad_in[23] = 1; idle(3);
    rd(12'h04C, r); chk("R6 output pin not sampled", r, 0);
    rd(12'h03C, r); chk("R6 pin data", r, 32'h0030_0000);
    wr(12'h064, 32'h0040_0000);
    rd(12'h03C, r); chk("R6 pull-up undriven", r, 32'h0070_0000);
    wr(12'h060, 32'h0040_0000);
    rd(12'h03C, r); chk("R6 pull-up off", r, 32'h0030_0000);
    pad_in[20] = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(12'h04C, r); chk("R8 same-edge read", r, 0);
    rd(12'h04C, r); chk("R8 change kept", r, 32'h0010_0000);

    wr(12'h004, 32'h20); wr(12'h074, 32'h20);
    per_b_in = 32'h20; per_a_in = 32'h0; pad_in[5] = 1; #1;
    chk("R9 pad_out from B", pad_out & 32'h20, 32'h20);
    chk("R9 pad_oe", pad_oe & 32'h20, 32'h20);
    chk("R9 to B", per_b_out, 32'h20);
    chk("R9 A sees 0", per_a_out, 0);
    wr(12'h070, 32'h20); #1;
    chk("R3 pad_out from A", pad_out & 32'h20, 0);
    chk("R3 to A", per_a_out, 32'h20);
    chk("R9 B ignored", per_b_out, 0);
    wr(12'h000, 32'h20); #1;
    chk("R9 back to controller oe", pad_oe & 32'h20, 0);
    chk("R9 back to controller fwd", per_a_out | per_b_out, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule